// File: doc/BRIEF.md
# Flash Write-Protect Window Guard

This block is the write-protection core of a serial NOR flash. It holds the 8-bit status register and turns its block-protect field and its top/bottom select bit into one protected address window. The window is a power-of-two fraction of the device. It sits either at the high end or at the low end of the device, and it can also be empty or cover the whole device.

Each program, erase or chip-erase request presented on the request port is checked against the window. The request is refused if any byte it touches lies inside the window, or if it runs past the end of the device. The verdict appears one clock after the request strobe. Reads are never refused.

The status register is loaded through a write port. That port is locked while the write-disable bit of the register is set and the external write-protect pin is driven low. Device size is `2**ADDR_W` bytes, so it is always a power of two.

Top module: `nor_wp_guard`

## Requirements
- R1: Synchronous active-low reset clears all 8 status bits and drives `rsp_vld` and `rsp_ok` to 0.
- R2: When the port is not locked, a status write stores all 8 bits of `sr_wr_data`, including the unused bits 0, 1 and 6, and they are visible on `status` on the clock after the write.
- R3: A status write is ignored while status bit 7 is 1 and `wp_n` is 0. With bit 7 set and `wp_n` at 1, the write takes effect.
- R4: The block-protect field BP is status bits 4:2, with bit 2 as the LSB. When BP is 0, every program or erase request that lies inside the device is accepted.
- R5: When BP is 7, the whole device is protected whatever status bit 5 holds, and every program or erase request with a non-zero length is refused.
- R6: For BP from 1 to 6, the protected length is `2**ADDR_W >> (7 - BP)`. When status bit 5 (top/bottom) is 0, the window ends at the last device address.
- R7: When status bit 5 is 1, the same protected length starts at address 0.
- R8: A program or erase request covering bytes [addr, addr+len) is refused if even one byte falls inside the window. A request that ends right at the window edge is accepted.
- R9: A program or erase request is refused when addr+len exceeds `2**ADDR_W`. A request ending exactly at the device end is not refused for that reason.
- R10: A program or erase request with length 0 touches no byte and is accepted.
- R11: Requests of kind read (`req_kind` = 0) are always accepted. Program is kind 1 and erase is kind 2.
- R12: A chip erase (`req_kind` = 3) ignores the address and length. It is accepted only when BP is 0.
- R13: `rsp_vld` is high exactly on the clock after each `req_vld` strobe. The verdict uses the status value held in the strobe cycle, not a value written in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| req_kind | input | 2 | 0 read, 1 program, 2 erase, 3 chip erase |
| req_addr | input | ADDR_W | First byte address of the request |
| req_len | input | ADDR_W+1 | Number of bytes in the request |
| sr_wr_en | input | 1 | Status register write strobe |
| sr_wr_data | input | 8 | Value to write to the status register |
| wp_n | input | 1 | Write-protect pin, active low |
| rsp_vld | output | 1 | Verdict valid, one clock after the strobe |
| rsp_ok | output | 1 | 1 means accepted, 0 means refused |
| status | output | 8 | Current status register |

## Verification
The bench targets the edges of the window one byte at a time. A one-byte request just outside the window must be accepted, and a two-byte request that spills one byte in must be refused. An off-by-one in the window bounds therefore flips one of these two verdicts.

It swaps the top/bottom bit for the same BP value, which exposes a decoder that ignores or inverts the placement. It also sets BP to 7 with both placements, which catches a design that lets the top/bottom bit shrink the full-device case.

It runs requests that end exactly at the device end, requests one byte past it, and zero-length requests, which exposes a wrong end-of-range comparison. Status writes are issued while locked and while unlocked, and one write lands in the same cycle as a request. A design that ignores the pin, or that decides with the newly written value, then reports the wrong status or the wrong verdict.

// File: rtl/nor_wp_pkg.sv
// Shared definitions for the flash write-protect guard.
// Holds the status bit positions, which the decoder depends on, and the request kinds.
package nor_wp_pkg;
    localparam int SR_W     = 8;
    localparam int BP_LSB   = 2;
    localparam int BP_W     = 3;
    localparam int TB_BIT   = 5;
    localparam int LOCK_BIT = 7;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_CHIP  = 2'd3
    } op_e;

    // Extract the block-protect field from a status value.
    function automatic logic [BP_W-1:0] bp_field(input logic [SR_W-1:0] sr);
        return sr[BP_LSB +: BP_W];
    endfunction
endpackage

// File: rtl/nor_wp_status.sv
// Status register with a lockable write port.
// Assumes: a write is refused while the lock bit is set and the pin is low.
// Reset is synchronous and clears every bit.
module nor_wp_status
    import nor_wp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SR_W-1:0] wr_data,
    input  logic            wp_n,
    output logic [SR_W-1:0] sr_q
);
    logic locked;

    // Lock condition: write-disable bit set and write-protect pin driven low.
    always_comb locked = sr_q[LOCK_BIT] & ~wp_n;

    // Register update: a whole-byte load when the port is not locked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (wr_en && !locked)
            sr_q <= wr_data;
    end
endmodule

// File: rtl/nor_wp_window.sv
// Decodes the status value into a protected window [win_lo, win_hi).
// Assumes ADDR_W >= 7, so that every protected fraction is at least one byte.
// Shifting by the inverted BP value equals shifting by 7 - BP.
module nor_wp_window
    import nor_wp_pkg::*;
#(
    parameter int ADDR_W = 23
) (
    input  logic [SR_W-1:0] sr,
    output logic [ADDR_W:0] win_lo,
    output logic [ADDR_W:0] win_hi,
    output logic            win_any
);
    localparam logic [ADDR_W:0] DEV_BYTES = {1'b1, {ADDR_W{1'b0}}};

    logic [BP_W-1:0] bp;
    logic [ADDR_W:0] plen;

    // Protected length: the device size divided by a power of two picked by BP.
    always_comb begin
        bp      = bp_field(sr);
        win_any = (bp != '0);
        plen    = DEV_BYTES >> (~bp);
    end

    // Placement: at the low end when the top/bottom bit is set, otherwise at the high end.
    always_comb begin
        if (!win_any) begin
            win_lo = '0;
            win_hi = '0;
        end else if (sr[TB_BIT]) begin
            win_lo = '0;
            win_hi = plen;
        end else begin
            win_lo = DEV_BYTES - plen;
            win_hi = DEV_BYTES;
        end
    end
endmodule

// File: rtl/nor_wp_verdict.sv
// Checks one request against the window and registers the accept flag.
// Assumes the window bounds are stable during the strobe cycle.
// Sums are kept two bits wider than the address, so that no in-range value wraps.
module nor_wp_verdict
    import nor_wp_pkg::*;
#(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W:0]   req_len,
    input  logic [ADDR_W:0]   win_lo,
    input  logic [ADDR_W:0]   win_hi,
    input  logic              win_any,
    output logic              rsp_vld,
    output logic              rsp_ok
);
    localparam int              EXT_W     = ADDR_W + 2;
    localparam logic [EXT_W-1:0] DEV_EXT  = {2'b01, {ADDR_W{1'b0}}};

    logic [EXT_W-1:0] a_ext;
    logic [EXT_W-1:0] e_ext;
    logic             beyond;
    logic             hits;
    logic             ok_c;
    op_e              kind;

    // Request span and its comparison against the device end and the window.
    always_comb begin
        a_ext  = {2'b00, req_addr};
        e_ext  = a_ext + {1'b0, req_len};
        beyond = e_ext > DEV_EXT;
        hits   = win_any && (req_len != '0)
                 && (a_ext < {1'b0, win_hi})
                 && (e_ext > {1'b0, win_lo});
    end

    // Verdict for each request kind.
    always_comb begin
        kind = op_e'(req_kind);
        case (kind)
            OP_READ:  ok_c = 1'b1;
            OP_CHIP:  ok_c = !win_any;
            default:  ok_c = !beyond && !hits;
        endcase
    end

    // Output stage: the verdict appears one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld <= 1'b0;
            rsp_ok  <= 1'b0;
        end else begin
            rsp_vld <= req_vld;
            if (req_vld)
                rsp_ok <= ok_c;
        end
    end
endmodule

// File: rtl/nor_wp_guard.sv
// Top of the flash write-protect guard.
// Assumes the device holds 2**ADDR_W bytes and that ADDR_W >= 7.
// A request is judged against the status value held in its strobe cycle.
module nor_wp_guard
    import nor_wp_pkg::*;
#(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W:0]   req_len,
    input  logic              sr_wr_en,
    input  logic [7:0]        sr_wr_data,
    input  logic              wp_n,
    output logic              rsp_vld,
    output logic              rsp_ok,
    output logic [7:0]        status
);
    logic [ADDR_W:0] win_lo;
    logic [ADDR_W:0] win_hi;
    logic            win_any;

    nor_wp_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sr_wr_en),
        .wr_data (sr_wr_data),
        .wp_n    (wp_n),
        .sr_q    (status)
    );

    nor_wp_window #(.ADDR_W(ADDR_W)) u_window (
        .sr      (status),
        .win_lo  (win_lo),
        .win_hi  (win_hi),
        .win_any (win_any)
    );

    nor_wp_verdict #(.ADDR_W(ADDR_W)) u_verdict (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (req_vld),
        .req_kind (req_kind),
        .req_addr (req_addr),
        .req_len  (req_len),
        .win_lo   (win_lo),
        .win_hi   (win_hi),
        .win_any  (win_any),
        .rsp_vld  (rsp_vld),
        .rsp_ok   (rsp_ok)
    );
endmodule

// File: rtl/nor_wp_guard_chk.sv
// Property checker for nor_wp_guard. It watches the ports only and is bound below.
module nor_wp_guard_chk #(
    parameter int ADDR_W = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ADDR_W:0]   req_len,
    input logic              sr_wr_en,
    input logic [7:0]        sr_wr_data,
    input logic              wp_n,
    input logic              rsp_vld,
    input logic              rsp_ok,
    input logic [7:0]        status
);
    logic [ADDR_W+1:0] span_end;
    logic              in_dev;
    logic              prog_like;

    always_comb begin
        span_end  = {2'b00, req_addr} + {1'b0, req_len};
        in_dev    = span_end <= {2'b01, {ADDR_W{1'b0}}};
        prog_like = (req_kind == 2'd1) || (req_kind == 2'd2);
    end

    // R13
    strobe_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    // R13
    idle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);
    // R2
    sr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && !(status[7] && !wp_n)) |=> (status == $past(sr_wr_data)));
    // R3
    sr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && status[7] && !wp_n) |=> $stable(status));
    // R11
    read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_kind == 2'd0) |=> rsp_ok);
    // R12
    chip_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_kind == 2'd3 && status[4:2] != 3'd0) |=> !rsp_ok);
    // R5
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && prog_like && status[4:2] == 3'd7 && req_len != '0) |=> !rsp_ok);
    // R4
    open_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && prog_like && status[4:2] == 3'd0 && in_dev) |=> rsp_ok);
    // R9
    past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && prog_like && !in_dev) |=> !rsp_ok);
endmodule

bind nor_wp_guard nor_wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_nor_wp_guard.sv
module sim_nor_wp_guard;
    localparam int AW = 23;

    typedef struct packed {
        logic [7:0]  sr;
        logic [1:0]  kind;
        logic [22:0] addr;
        logic [23:0] len;
        logic        ok;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 2'd1, 23'h000000, 24'h800000, 1'b1, 4'd4},  // R4 whole device, open
        '{8'h04, 2'd1, 23'h7DFFFF, 24'h000001, 1'b1, 4'd8},  // R8 edge below top window
        '{8'h04, 2'd1, 23'h7DFFFF, 24'h000002, 1'b0, 4'd8},  // R8 one byte inside
        '{8'h04, 2'd2, 23'h7E0000, 24'h001000, 1'b0, 4'd6},  // R6 top 128 KB
        '{8'h18, 2'd1, 23'h3FFFFF, 24'h000001, 1'b1, 4'd6},  // R6 top 4 MB, below
        '{8'h18, 2'd2, 23'h400000, 24'h000010, 1'b0, 4'd6},  // R6 top 4 MB, inside
        '{8'h38, 2'd1, 23'h3FFFFF, 24'h000001, 1'b0, 4'd7},  // R7 bottom 4 MB
        '{8'h38, 2'd1, 23'h400000, 24'h400000, 1'b1, 4'd7},  // R7 upper half free
        '{8'h24, 2'd2, 23'h020000, 24'h001000, 1'b1, 4'd7},  // R7 bottom 128 KB, above
        '{8'h24, 2'd2, 23'h01F000, 24'h001000, 1'b0, 4'd7},  // R7 bottom 128 KB, inside
        '{8'h1C, 2'd1, 23'h000123, 24'h000001, 1'b0, 4'd5},  // R5 all, top select
        '{8'h3C, 2'd1, 23'h7FFFFF, 24'h000001, 1'b0, 4'd5},  // R5 all, bottom select
        '{8'h1C, 2'd0, 23'h000000, 24'h000010, 1'b1, 4'd11}, // R11 read while all locked
        '{8'h1C, 2'd1, 23'h000010, 24'h000000, 1'b1, 4'd10}, // R10 zero length
        '{8'h00, 2'd1, 23'h7FFFFF, 24'h000002, 1'b0, 4'd9},  // R9 one past end
        '{8'h00, 2'd3, 23'h000000, 24'h000000, 1'b1, 4'd12}, // R12 chip erase open
        '{8'h04, 2'd3, 23'h000000, 24'h000000, 1'b0, 4'd12}, // R12 chip erase blocked
        '{8'h10, 2'd1, 23'h6FFFFF, 24'h000001, 1'b1, 4'd6},  // R6 top 1 MB, below
        '{8'h10, 2'd1, 23'h6FFFFF, 24'h000002, 1'b0, 4'd6},  // R6 top 1 MB, spill
        '{8'h00, 2'd0, 23'h7FFFFF, 24'h000010, 1'b1, 4'd11}  // R11 read past end
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_vld = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [AW-1:0] req_addr = '0;
    logic [AW:0]   req_len = '0;
    logic          sr_wr_en = 1'b0;
    logic [7:0]    sr_wr_data = '0;
    logic          wp_n = 1'b1;
    logic          rsp_vld;
    logic          rsp_ok;
    logic [7:0]    status;

    int  n_run = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    nor_wp_guard #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_kind(req_kind),
        .req_addr(req_addr), .req_len(req_len), .sr_wr_en(sr_wr_en),
        .sr_wr_data(sr_wr_data), .wp_n(wp_n), .rsp_vld(rsp_vld),
        .rsp_ok(rsp_ok), .status(status)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic sr_write(input logic [7:0] v);
        @(negedge clk);
        sr_wr_en = 1'b1;
        sr_wr_data = v;
        @(negedge clk);
        sr_wr_en = 1'b0;
    endtask

    task automatic request(input logic [1:0] k, input logic [AW-1:0] a, input logic [AW:0] l);
        @(negedge clk);
        req_vld = 1'b1;
        req_kind = k;
        req_addr = a;
        req_len = l;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status after reset", 32'(status), 32'h00);
        check("R1 rsp_vld after reset", 32'(rsp_vld), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            sr_write(VECS[i].sr);
            request(VECS[i].kind, VECS[i].addr, VECS[i].len);
            check($sformatf("R%0d vector %0d verdict", VECS[i].rq, i),
                  32'(rsp_ok), 32'(VECS[i].ok));
        end

        // R2 unused bits are stored
        sr_write(8'h43);
        check("R2 bits 0,1,6 stored", 32'(status), 32'h43);
        sr_write(8'hFF);
        check("R2 full byte stored", 32'(status), 32'hFF);

        // R3 locked by bit 7 together with the pin
        sr_write(8'h80);
        wp_n = 1'b0;
        sr_write(8'h00);
        check("R3 write ignored while locked", 32'(status), 32'h80);
        request(2'd1, 23'h0, 24'h1);
        check("R3 open window still open", 32'(rsp_ok), 32'h1);
        wp_n = 1'b1;
        sr_write(8'h00);
        check("R3 write taken with pin high", 32'(status), 32'h00);

        // R13 timing, and a status write in the strobe cycle
        @(negedge clk);
        req_vld = 1'b1; req_kind = 2'd1; req_addr = 23'h7FFFFF; req_len = 24'h1;
        sr_wr_en = 1'b1; sr_wr_data = 8'h1C;
        @(negedge clk);
        req_vld = 1'b0; sr_wr_en = 1'b0;
        check("R13 rsp_vld one clock after strobe", 32'(rsp_vld), 32'h1);
        check("R13 verdict from old status", 32'(rsp_ok), 32'h1);
        @(negedge clk);
        check("R13 rsp_vld drops", 32'(rsp_vld), 32'h0);
        request(2'd1, 23'h7FFFFF, 24'h1);
        check("R13 new status takes effect", 32'(rsp_ok), 32'h0);

        // R1 reset in the middle of a run
        sr_write(8'h9C);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 status cleared by reset", 32'(status), 32'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule